// File: doc/BRIEF.md
# Direct-Drive Pixel Unpacker

This block turns one pixel per clock into three 8-bit converter drive words, with no colour lookup. Three 8-bit pixel ports (red, green, blue) come in, along with a two-bit format code and a two-bit source select. The format code chooses how the incoming bits are laid out. In full-width format each byte passes through unchanged. In 5:5:5 format, fifteen bits are packed across the red and green ports. In 3:3:2 format, a single byte comes from the port named by the source select.

In every format, each colour field is placed at the top of its output word and the bits below it are zero. The outputs are registered once, so a pixel shows at the outputs one clock after it is sampled. A synchronous reset clears the outputs to zero. Format code 3 is unassigned and produces black.

Top module: `pix_direct_fmt`

## Requirements
- R1: With fmt=0 (full width), the outputs one clock later are dac_r=pin_r, dac_g=pin_g and dac_b=pin_b.
- R2: With fmt=1 (5:5:5), dac_r[7:3]=pin_r[7:3]. dac_g[7:3]={pin_r[2:0],pin_g[7:6]}. dac_b[7:3]=pin_g[5:1].
- R3: With fmt=1, bits [2:0] of every output are zero, and pin_g[0] and pin_b have no effect on any output.
- R4: With fmt=2 (3:3:2), the selected byte S is split as follows: dac_r[7:5]=S[7:5], dac_g[7:5]=S[4:2], dac_b[7:6]=S[1:0].
- R5: With fmt=2, dac_r[4:0] and dac_g[4:0] are zero, and dac_b[5:0] is zero.
- R6: With fmt=2, src_sel selects S: 0 selects pin_r, 1 selects pin_g, 2 selects pin_b, and 3 selects pin_r. Ports that are not selected have no effect.
- R7: Each input sample appears at the outputs exactly one clock later, and a new sample is taken on every clock.
- R8: When rst is high at a clock edge, all outputs are zero after that edge. With fmt=3, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt | input | 2 | Format code: 0 full width, 1 5:5:5, 2 3:3:2 |
| src_sel | input | 2 | Source port for 3:3:2 format |
| pin_r | input | 8 | Red pixel port |
| pin_g | input | 8 | Green pixel port |
| pin_b | input | 8 | Blue pixel port |
| dac_r | output | 8 | Red converter word |
| dac_g | output | 8 | Green converter word |
| dac_b | output | 8 | Blue converter word |

## Verification
The only state is the output register, so any fault shows at the outputs on the very next clock after the pixel that exposes it. A mis-wired field shows as shifted or swapped bits in a single output word. A missing zero-fill shows as stray bits in the low part of a word. A wrong source select shows as one port's byte appearing where another's was expected. Random pixels are run under every format and select value, and they reveal these faults within a few cycles.

// File: rtl/pix_direct_fmt.sv
module pix_direct_fmt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   fmt,
  input  logic [1:0]   src_sel,
  input  logic [W-1:0] pin_r,
  input  logic [W-1:0] pin_g,
  input  logic [W-1:0] pin_b,
  output logic [W-1:0] dac_r,
  output logic [W-1:0] dac_g,
  output logic [W-1:0] dac_b
);

  logic [7:0] sel_byte;
  logic [7:0] n_r, n_g, n_b;

  assign sel_byte = (src_sel == 2'd1) ? pin_g :
                    (src_sel == 2'd2) ? pin_b : pin_r;

  always_comb begin
    n_r = '0; n_g = '0; n_b = '0;
    case (fmt)
      2'd0: begin n_r = pin_r; n_g = pin_g; n_b = pin_b; end
      2'd1: begin
        n_r = {pin_r[7:3], 3'b000};
        n_g = {pin_r[2:0], pin_g[7:6], 3'b000};
        n_b = {pin_g[5:1], 3'b000};
      end
      2'd2: begin
        n_r = {sel_byte[7:5], 5'b00000};
        n_g = {sel_byte[4:2], 5'b00000};
        n_b = {sel_byte[1:0], 6'b000000};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_r <= '0; dac_g <= '0; dac_b <= '0;
    end else begin
      dac_r <= n_r; dac_g <= n_g; dac_b <= n_b;
    end
  end

  AST_FULL_PASS: assert property (@(posedge clk) disable iff (rst)
    fmt == 2'd0 |=> dac_r == $past(pin_r) && dac_g == $past(pin_g) && dac_b == $past(pin_b)); // R1
  AST_555_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    fmt == 2'd1 |=> dac_r[2:0] == 3'b0 && dac_g[2:0] == 3'b0 && dac_b[2:0] == 3'b0); // R3
  AST_555_RED: assert property (@(posedge clk) disable iff (rst)
    fmt == 2'd1 |=> dac_r[7:3] == $past(pin_r[7:3])); // R2
  AST_332_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    fmt == 2'd2 |=> dac_r[4:0] == 5'b0 && dac_g[4:0] == 5'b0 && dac_b[5:0] == 6'b0); // R5
  AST_332_BLUE_SRC: assert property (@(posedge clk) disable iff (rst)
    fmt == 2'd2 && src_sel == 2'd2 |=> dac_b[7:6] == $past(pin_b[1:0])); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> dac_r == '0 && dac_g == '0 && dac_b == '0); // R8

endmodule

// File: tb/pix_direct_fmt_bench.sv
module pix_direct_fmt_bench;
  logic clk = 0, rst = 1;
  logic [1:0] fmt = 0, src_sel = 0;
  logic [7:0] pin_r = 0, pin_g = 0, pin_b = 0;
  logic [7:0] dac_r, dac_g, dac_b;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pix_direct_fmt u_pix_direct_fmt (.clk, .rst, .fmt, .src_sel, .pin_r, .pin_g, .pin_b,
                                   .dac_r, .dac_g, .dac_b);

  function automatic logic [23:0] model(input logic [1:0] f, input logic [1:0] s,
                                        input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    logic [7:0] sb;
    sb = (s == 1) ? g : (s == 2) ? b : r;
    case (f)
      0: return {r, g, b};
      1: return {r[7:3], 3'd0, r[2:0], g[7:6], 3'd0, g[5:1], 3'd0};
      2: return {sb[7:5], 5'd0, sb[4:2], 5'd0, sb[1:0], 6'd0};
      default: return 24'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [23:0] exp);
    checks++;
    if ({dac_r, dac_g, dac_b} !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, {dac_r, dac_g, dac_b}, exp);
    end
  endtask

  task automatic apply(input string req, input logic [1:0] f, input logic [1:0] s,
                       input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    fmt = f; src_sel = s; pin_r = r; pin_g = g; pin_b = b;
    @(posedge clk); #1;
    chk(req, model(f, s, r, g, b));
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(posedge clk); #1;
    chk("R8 reset", 24'd0);
    rst = 0;
    apply("R1 full", 0, 0, 8'hA5, 8'h3C, 8'hF0);
    apply("R2 555", 1, 0, 8'hFF, 8'h00, 8'h00);
    apply("R2 555", 1, 0, 8'h07, 8'hC0, 8'h00);
    apply("R2 555", 1, 0, 8'h00, 8'h3E, 8'h00);
    apply("R3 unused bits", 1, 0, 8'h00, 8'h01, 8'hFF);
    apply("R4 332 red", 2, 0, 8'hFF, 8'h00, 8'h00);
    apply("R5 zero fill", 2, 0, 8'hE3, 8'h1C, 8'h00);
    apply("R6 sel green", 2, 1, 8'hFF, 8'h5A, 8'hFF);
    apply("R6 sel blue", 2, 2, 8'hFF, 8'h00, 8'hB7);
    apply("R6 sel 3 red", 2, 3, 8'h96, 8'hFF, 8'hFF);
    apply("R8 fmt3 black", 3, 0, 8'hFF, 8'hFF, 8'hFF);
    for (int i = 0; i < 400; i++)
      apply("R7 random", 2'($urandom), 2'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    rst = 1;
    @(posedge clk); #1;
    chk("R8 reset mid", 24'd0);
    done = 1;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL R7 watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule